// File: doc/BRIEF.md
# Lag-Four Complementary Multiply-With-Carry Random Word Generator

This block produces a stream of 64-bit pseudo-random words from a complementary multiply-with-carry recurrence with a lag of four. It keeps four 64-bit history words and one carry word. Each step takes the oldest history word `x` and the carry `c` and forms `t = a*x + c`, where `a = 2^62 + 2^47 + 2`. The modulus is `b = 2^64 - 1`. The step keeps `floor(t/b)` as the next carry and emits `(b - 1) - (t mod b)` as the new word. That word becomes the newest history entry and the oldest entry is dropped.

The multiplier has only three set bits, so the wide product is built from three shifted copies of `x` split into a high and a low 64-bit half. Since `2^64 ≡ 1 (mod b)`, the remainder comes from adding the two halves with an end-around carry. A result equal to `b` is folded to zero, and the quotient is corrected to match. No 128-bit multiplier or divider exists. A parameter `PIPE` inserts a register between the product split and the fold. The default is `PIPE = 1`, and in that configuration each step takes two cycles and a busy flag holds off further requests.

Software seeds the generator through a load port that writes all four history words and the carry in one cycle. With seed words below `b` and a carry below `a`, the sequence period is near 2^318.

Top module: `cmwc64_gen`

## Requirements
- R1: Synchronous active-low reset sets history word 0 (the oldest, used first) to 123456789 and the other three words and the carry to zero. After reset, `rnd_valid` and `busy` are 0.
- R2: Each step emits `rnd_out = (2^64 - 2) - (t mod (2^64 - 1))`, where `t = (2^62 + 2^47 + 2) * oldest + carry`.
- R3: Each step replaces the carry with `floor(t / (2^64 - 1))`. The next step's result must reflect this carry.
- R4: After a step, the history shifts toward the oldest slot and the emitted word enters the newest slot. The word emitted by step n is the oldest operand of step n+4.
- R5: `rnd_out` never equals 2^64 - 1, because a remainder equal to the modulus folds to zero. The carry stays below the multiplier.
- R6: With PIPE=1, a request accepted at clock edge k makes `rnd_valid` high for exactly the one cycle after edge k+1, with the new word on `rnd_out`.
- R7: With PIPE=1, `busy` is high for the one cycle after an accepted request. A request seen while `busy` is high is ignored and does not advance the sequence.
- R8: `seed_load` has priority over `next_req` in the same cycle. It writes `seed_hist[64*i +: 64]` into history word i (i = 0 is the oldest) and `seed_carry` into the carry. It performs no step and produces no `rnd_valid` pulse.
- R9: A `seed_load` during the `busy` cycle cancels the pending step. No `rnd_valid` follows, and the next step starts from the loaded seeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset to default seeds |
| seed_load | input | 1 | Load history words and carry from the seed ports |
| seed_hist | input | 256 | Four seed words, word i at bits 64*i+63..64*i, word 0 oldest; each below 2^64-1 |
| seed_carry | input | 64 | Seed carry, below 2^62+2^47+2 |
| next_req | input | 1 | Request one step |
| busy | output | 1 | Step in progress; requests ignored |
| rnd_out | output | 64 | Most recently produced word |
| rnd_valid | output | 1 | One-cycle pulse when `rnd_out` holds a new word |

## Verification
In the default configuration a request driven before edge k is checked twice. `busy` is sampled at the falling edge after edge k, and the word and `rnd_valid` are sampled at the falling edge after edge k+1. Seed loads take effect at the edge that samples them, so the next request already uses the loaded words. Every expected word comes from a bench model that uses a true 128-bit product with division and remainder by 2^64-1, run over default, zero, maximal and generated seed sets for hundreds of steps each. Ignored requests and cancelled steps are confirmed by checking the next produced word against a model that was not advanced.

// File: rtl/cmwc_pkg.sv
// Package: shared widths, constants and the sparse multiplier shape for
// the lag-four complementary multiply-with-carry generator.
// Assumes the multiplier is a sum of MUL_TERMS powers of two, each below 2^63.
package cmwc_pkg;
    localparam int W         = 64;
    localparam int LAG       = 4;
    localparam int MUL_TERMS = 3;
    typedef logic [W-1:0] word_t;
    localparam int unsigned MUL_SHIFTS [MUL_TERMS] = '{62, 47, 1};
    localparam word_t MULT_A = (word_t'(1) << 62) | (word_t'(1) << 47) | (word_t'(1) << 1);
    localparam word_t MOD_B  = '1;
    localparam word_t SEED0  = word_t'(123456789);
endpackage

// File: rtl/cmwc_mulsplit.sv
// Module: forms t = a*x + c for the sparse multiplier a and returns t as
// two 64-bit halves {hi, lo}, using only shifted copies of x and adds.
// Assumes c < a and x < 2^64-1, so hi < 2^63 and needs no 65th bit.
module cmwc_mulsplit
    import cmwc_pkg::*;
(
    input  word_t x,
    input  word_t c,
    output word_t hi,
    output word_t lo
);
    localparam int LO_W = W + 2;

    logic [LO_W-1:0] lo_acc;
    word_t           hi_acc;

    // Sum the low and high slices of every shifted term plus the carry.
    always_comb begin
        lo_acc = {2'b00, c};
        hi_acc = '0;
        for (int i = 0; i < MUL_TERMS; i++) begin
            lo_acc = lo_acc + {2'b00, word_t'(x << MUL_SHIFTS[i])};
            hi_acc = hi_acc + word_t'(x >> (W - MUL_SHIFTS[i]));
        end
        hi = hi_acc + word_t'(lo_acc[LO_W-1:W]);
        lo = lo_acc[W-1:0];
    end
endmodule

// File: rtl/cmwc_fold.sv
// Module: reduces t = hi*2^64 + lo modulo 2^64-1 by an end-around add and
// gives the quotient, the remainder and the complemented output word.
// Assumes hi < 2^63, so hi+lo < 2^64+2^63 and the end-around add cannot wrap.
module cmwc_fold
    import cmwc_pkg::*;
(
    input  word_t hi,
    input  word_t lo,
    output word_t quo,
    output word_t rem,
    output word_t val
);
    logic [W:0] sum;
    word_t      r0;
    logic       wrap;
    logic       fix;

    // Fold halves, treat a residue equal to the modulus as zero, fix quotient.
    always_comb begin
        sum  = {1'b0, hi} + {1'b0, lo};
        wrap = sum[W];
        r0   = sum[W-1:0] + word_t'(wrap);
        fix  = (r0 == MOD_B);
        rem  = fix ? '0 : r0;
        quo  = hi + word_t'(wrap) + word_t'(fix);
        val  = (MOD_B - word_t'(1)) - rem;
    end
endmodule

// File: rtl/cmwc_hist.sv
// Module: four-deep history of produced words plus the carry register.
// Slot 0 is the oldest word and feeds the next step. A load writes all
// slots and the carry. A step shifts toward slot 0 and appends new_word.
// Assumes loaded words are below 2^64-1 and the loaded carry is below a.
module cmwc_hist
    import cmwc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [LAG*W-1:0]   load_words,
    input  word_t              load_carry,
    input  logic               step,
    input  word_t              new_word,
    input  word_t              new_carry,
    output word_t              oldest,
    output word_t              carry
);
    word_t hist_q [LAG];
    word_t carry_q;

    for (genvar g = 0; g < LAG; g++) begin : g_slot
        localparam word_t RST_VAL = (g == 0) ? SEED0 : '0;
        word_t shift_in;
        if (g == LAG - 1) begin : g_newest
            assign shift_in = new_word;
        end else begin : g_inner
            assign shift_in = hist_q[g+1];
        end
        // Hold, load or shift one history slot.
        always_ff @(posedge clk) begin
            if (!rst_n)    hist_q[g] <= RST_VAL;
            else if (load) hist_q[g] <= load_words[g*W +: W];
            else if (step) hist_q[g] <= shift_in;
        end
    end

    // Hold, load or update the carry word.
    always_ff @(posedge clk) begin
        if (!rst_n)    carry_q <= '0;
        else if (load) carry_q <= load_carry;
        else if (step) carry_q <= new_carry;
    end

    assign oldest = hist_q[0];
    assign carry  = carry_q;

    assert_carry_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        carry_q < MULT_A);
endmodule

// File: rtl/cmwc64_gen.sv
// Module: top of the lag-four complementary multiply-with-carry generator.
// PIPE=1 registers the product halves and takes two cycles per step, with
// busy high in between. PIPE=0 completes a step in the cycle it is requested.
// A seed load beats a request and cancels a pending step.
module cmwc64_gen
    import cmwc_pkg::*;
#(
    parameter bit PIPE = 1'b1
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               seed_load,
    input  logic [LAG*W-1:0]   seed_hist,
    input  logic [W-1:0]       seed_carry,
    input  logic               next_req,
    output logic               busy,
    output logic [W-1:0]       rnd_out,
    output logic               rnd_valid
);
    word_t oldest, carry;
    word_t prod_hi, prod_lo;
    word_t fold_hi, fold_lo;
    word_t new_carry, new_rem, new_word;
    logic  commit;
    word_t out_q;
    logic  valid_q;

    cmwc_hist u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (seed_load),
        .load_words (seed_hist),
        .load_carry (seed_carry),
        .step       (commit),
        .new_word   (new_word),
        .new_carry  (new_carry),
        .oldest     (oldest),
        .carry      (carry)
    );

    cmwc_mulsplit u_mul (
        .x  (oldest),
        .c  (carry),
        .hi (prod_hi),
        .lo (prod_lo)
    );

    if (PIPE) begin : g_pipe
        word_t st_hi, st_lo;
        logic  st_vld;
        logic  accept;
        assign accept = next_req && !st_vld && !seed_load;
        // Capture the product halves of an accepted request; a load cancels.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_vld <= 1'b0;
                st_hi  <= '0;
                st_lo  <= '0;
            end else begin
                st_vld <= accept;
                if (accept) begin
                    st_hi <= prod_hi;
                    st_lo <= prod_lo;
                end
            end
        end
        assign fold_hi = st_hi;
        assign fold_lo = st_lo;
        assign commit  = st_vld && !seed_load;
        assign busy    = st_vld;

        assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (next_req && !busy && !seed_load) |=> busy);
        assert_valid_follows_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
            rnd_valid |-> $past(busy));
        assert_no_back_to_back_R7: assert property (@(posedge clk) disable iff (!rst_n)
            busy |=> !busy);
        assert_load_cancels_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (seed_load && busy) |=> (!busy && !rnd_valid));
    end else begin : g_direct
        assign fold_hi = prod_hi;
        assign fold_lo = prod_lo;
        assign commit  = next_req && !seed_load;
        assign busy    = 1'b0;
    end

    cmwc_fold u_fold (
        .hi  (fold_hi),
        .lo  (fold_lo),
        .quo (new_carry),
        .rem (new_rem),
        .val (new_word)
    );

    // Register the produced word and raise the valid pulse for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= commit;
            if (commit) out_q <= new_word;
        end
    end

    assign rnd_out   = out_q;
    assign rnd_valid = valid_q;

    assert_out_not_modulus_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_valid |-> (rnd_out != MOD_B));
    assert_load_no_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> !rnd_valid);
    assert_rem_below_modulus_R2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (new_rem != MOD_B));
endmodule

// File: tb/cmwc64_gen_tb.sv
module cmwc64_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [127:0] A128 = (128'd1 << 62) + (128'd1 << 47) + 128'd2;
    localparam logic [127:0] B128 = (128'd1 << 64) - 128'd1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         seed_load = 1'b0;
    logic [255:0] seed_hist = '0;
    logic [63:0]  seed_carry = '0;
    logic         next_req = 1'b0;
    logic         busy;
    logic [63:0]  rnd_out;
    logic         rnd_valid;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [63:0] m_hist [4];
    logic [63:0] m_carry;
    logic [63:0] gen_state = 64'h9E37_79B9_7F4A_7C15;

    cmwc64_gen u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .seed_load  (seed_load),
        .seed_hist  (seed_hist),
        .seed_carry (seed_carry),
        .next_req   (next_req),
        .busy       (busy),
        .rnd_out    (rnd_out),
        .rnd_valid  (rnd_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_defaults();
        m_hist[0] = 64'd123456789;
        for (int i = 1; i < 4; i++) m_hist[i] = '0;
        m_carry = '0;
    endtask

    // Reference step with a full-width product, divide and remainder.
    task automatic model_step(output logic [63:0] v);
        logic [127:0] t, q, r;
        t = A128 * {64'd0, m_hist[0]} + {64'd0, m_carry};
        q = t / B128;
        r = t % B128;
        v = 64'(B128 - 128'd1 - r);
        m_carry = q[63:0];
        for (int i = 0; i < 3; i++) m_hist[i] = m_hist[i+1];
        m_hist[3] = v;
    endtask

    function automatic logic [63:0] next_gen(input logic [63:0] s);
        logic [63:0] v;
        v = s ^ (s << 13);
        v = v ^ (v >> 7);
        v = v ^ (v << 17);
        return v;
    endfunction

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        next_req = 1'b0;
        seed_load = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_defaults();
        @(negedge clk);
        check(rnd_valid === 1'b0, "R1 valid low after reset", {63'd0, rnd_valid}, 64'd0);
        check(busy === 1'b0, "R1 busy low after reset", {63'd0, busy}, 64'd0);
    endtask

    // Drive seeds on the load port and mirror them into the model.
    task automatic load_seeds(input logic [63:0] w0, input logic [63:0] w1, input logic [63:0] w2,
                              input logic [63:0] w3, input logic [63:0] c, input bit with_req);
        @(negedge clk);
        seed_hist = {w3, w2, w1, w0};
        seed_carry = c;
        seed_load = 1'b1;
        next_req = with_req;
        @(negedge clk);
        seed_load = 1'b0;
        next_req = 1'b0;
        m_hist[0] = w0; m_hist[1] = w1; m_hist[2] = w2; m_hist[3] = w3;
        m_carry = c;
        check(busy === 1'b0, "R8 load with request starts no step", {63'd0, busy}, 64'd0);
        @(negedge clk);
        check(rnd_valid === 1'b0, "R8 load gives no valid pulse", {63'd0, rnd_valid}, 64'd0);
    endtask

    task automatic do_step(input string tag);
        logic [63:0] exp;
        @(negedge clk);
        next_req = 1'b1;
        @(negedge clk);
        next_req = 1'b0;
        check(busy === 1'b1 && rnd_valid === 1'b0, "R7 busy one cycle after accept",
              {62'd0, busy, rnd_valid}, 64'd2);
        @(negedge clk);
        model_step(exp);
        check(rnd_valid === 1'b1 && rnd_out === exp, tag, rnd_out, exp);
        check(busy === 1'b0, "R6 busy clear at valid", {63'd0, busy}, 64'd0);
    endtask

    task automatic run_steps(input int n, input string tag);
        for (int k = 0; k < n; k++) do_step(tag);
    endtask

    task automatic gen_seed_set();
        logic [63:0] w [4];
        logic [63:0] c;
        for (int i = 0; i < 4; i++) begin
            gen_state = next_gen(gen_state);
            w[i] = (gen_state == '1) ? 64'd0 : gen_state;
        end
        gen_state = next_gen(gen_state);
        c = 64'({64'd0, gen_state} % A128);
        load_seeds(w[0], w[1], w[2], w[3], c, 1'b0);
    endtask

    initial begin
        logic [63:0] exp;
        apply_reset();
        do_step("R1 first word from default seeds");
        run_steps(3, "R3 carry carried into next step");
        run_steps(4, "R4 produced words reused as oldest");
        run_steps(200, "R2 default-seed sequence");

        // R7: request held across the busy cycle gives exactly one step.
        @(negedge clk);
        next_req = 1'b1;
        @(negedge clk);
        check(busy === 1'b1, "R7 busy after accept (held request)", {63'd0, busy}, 64'd1);
        @(negedge clk);
        next_req = 1'b0;
        model_step(exp);
        check(rnd_valid === 1'b1 && rnd_out === exp, "R7 single step from held request", rnd_out, exp);
        @(negedge clk);
        check(rnd_valid === 1'b0 && busy === 1'b0, "R7 request during busy ignored",
              {62'd0, busy, rnd_valid}, 64'd0);
        do_step("R7 sequence not advanced by ignored request");

        // R8: load and request in the same cycle, then the sweep over seed sets.
        load_seeds('0, '0, '0, '0, '0, 1'b1);
        run_steps(300, "R8 zero seeds sequence");
        load_seeds(64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFE,
                   64'hFFFF_FFFF_FFFF_FFFE, 64'(A128 - 128'd1), 1'b1);
        run_steps(300, "R5 maximal seeds sequence");
        for (int s = 0; s < 6; s++) begin
            gen_seed_set();
            run_steps(300, "R2 generated seed sequence");
        end

        // R9: load during the busy cycle cancels the pending step.
        @(negedge clk);
        next_req = 1'b1;
        @(negedge clk);
        next_req = 1'b0;
        check(busy === 1'b1, "R9 busy before cancel", {63'd0, busy}, 64'd1);
        seed_hist = {64'd4, 64'd3, 64'd2, 64'hFFFF_FFFF_FFFF_FFFE};
        seed_carry = 64'd77;
        seed_load = 1'b1;
        @(negedge clk);
        seed_load = 1'b0;
        m_hist[0] = 64'hFFFF_FFFF_FFFF_FFFE; m_hist[1] = 64'd2; m_hist[2] = 64'd3; m_hist[3] = 64'd4;
        m_carry = 64'd77;
        check(rnd_valid === 1'b0 && busy === 1'b0, "R9 cancelled step gives no pulse",
              {62'd0, busy, rnd_valid}, 64'd0);
        run_steps(8, "R9 sequence from loaded seeds after cancel");

        // R1: reset mid-run returns to the default sequence.
        apply_reset();
        run_steps(8, "R1 default sequence after second reset");

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule